// File: doc/BRIEF.md
# ECC controller register bank

This block is the control and status register file of an ECC memory controller. Software reaches it over a simple word-wide register bus. The bus has a byte address, a write strobe, a full-word qualifier and write data, and it returns read data combinationally. The file holds nine 32-bit registers, selected by the byte address shifted right by two:

| Index | Register |
|---|---|
| 0 | enable |
| 1 | delay |
| 2 | fault status |
| 3 | video configuration |
| 4 | fault address 0 |
| 5 | fault address 1 |
| 6 | diagnostic |
| 7 | event count 0 |
| 8 | event count 1 |

A static implementation code is set as a parameter. It picks the enable-register write mask and the enable bits that survive a reset, and it is forced into bits 31:28 of the enable register.

The memory datapath reports detected errors on a fault-capture port. A capture fills the fault status and fault address registers. It also raises an interrupt, which stays high until software writes the fault status register. Implementation code 0 also has a small byte-wide diagnostic window.

Top module: `ecc_csr_bank`

## Requirements
- R1: A full-word write to index 0 stores `wdata & 0x00000103` for code 0. For any other code it stores `(wdata & 0x00000BFF) | (code << 28)`. Bits 31:28 of the enable register always read as the code.
- R2: A write to index 1 stores `wdata & 0x7FFFFFFF`, so bit 31 of the delay register always reads 0.
- R3: After reset the register values are:
  - delay reads 0x00000020.
  - fault address 0 reads 0x07C00000.
  - fault status, video configuration, fault address 1, diagnostic and both event counters read 0.
  - irq is low.
  - enable bits outside the kept set (see R4) read 0.
- R4: Reset keeps only part of the enable register. For code 0 only bit 8 is kept. For other codes bits 31:24, 11 and 9:2 are kept. All other enable bits clear.
- R5: Writes to index 4 and 5 have no effect; these registers change only through fault capture.
- R6: An access with `reg_word` low is not a full 32-bit access. It writes nothing and reads 0.
- R7: Index 9 and above reads 0, and writes there change no register. Event count 1 (index 8) is storage separate from event count 0 (index 7).
- R8: An accepted fault arrives when `flt_valid` is high with `flt_ce` or `flt_ue` set. If fault status bits 0 and 3 are both clear at that point, the fault loads:
  - bit 0 with `flt_ce` and bit 3 with `flt_ue`;
  - bits 15:8 with `flt_syndrome`;
  - fault address 0 with `flt_far0` and fault address 1 with `flt_far1`.
  All other fault status bits are unchanged.
- R9: An accepted fault that arrives while fault status bit 0 or 3 is set does three things. It sets bit 16 (multiple errors) and ORs its flags into bits 0 and 3. It leaves the syndrome and both fault addresses unchanged.
- R10: irq goes high one cycle after an accepted fault that has `flt_ue` set, or `flt_ce` set while enable bit 1 is 1. It then stays high until the fault status register is written.
- R11: Any write to index 2 stores the full word and drops irq in the next cycle. A fault presented in the same cycle as that write is discarded.
- R12: When the code is 0, a four-byte diagnostic window supports byte writes and byte reads, with the byte selected by `dg_addr`. For any other code, window writes are ignored and reads return 0.
- R13: Indices 3, 6, 7 and 8 store and return the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the register |
| reg_wr | input | 1 | Write strobe |
| reg_word | input | 1 | High for a full 32-bit access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| flt_valid | input | 1 | Fault report strobe |
| flt_ce | input | 1 | Correctable error flag |
| flt_ue | input | 1 | Uncorrectable error flag |
| flt_syndrome | input | 8 | Syndrome of the reported error |
| flt_far0 | input | 32 | Value for fault address 0 |
| flt_far1 | input | 32 | Value for fault address 1 |
| irq | output | 1 | Fault interrupt, level |
| dg_addr | input | $clog2(DIAG_BYTES) | Diagnostic window byte select |
| dg_wr | input | 1 | Diagnostic window byte write |
| dg_wdata | input | 8 | Diagnostic write byte |
| dg_rdata | output | 8 | Diagnostic read byte |

## Verification
The properties assume that `flt_valid` is a single-cycle strobe, sampled on the same edge as the bus write. They also assume that when the bus and the fault port collide, the bus write wins. The stimulus drives every input on the falling edge and holds each bus or fault action for one cycle. Random fault reports therefore land only between bus transactions, and the one deliberate collision is directed. Random addresses cover the whole index space, including the unused indices, so the read-zero properties see real traffic.

// File: rtl/ecc_csr_pkg.sv
// Shared constants for the ECC controller register bank: register
// indices, reset values, fault status bit positions and the
// implementation-dependent enable masks.
package ecc_csr_pkg;

    localparam int NUM_REGS    = 9;
    localparam int IDX_EN      = 0;
    localparam int IDX_DLY     = 1;
    localparam int IDX_FSTAT   = 2;
    localparam int IDX_VCFG    = 3;
    localparam int IDX_FADDR0  = 4;
    localparam int IDX_FADDR1  = 5;
    localparam int IDX_DREG    = 6;
    localparam int IDX_EVC0    = 7;
    localparam int IDX_EVC1    = 8;

    localparam logic [31:0] DLY_RST    = 32'h0000_0020;
    localparam logic [31:0] FADDR0_RST = 32'h07C0_0000;
    localparam logic [31:0] DLY_WMASK  = 32'h7FFF_FFFF;

    localparam int FS_CE  = 0;
    localparam int FS_UE  = 3;
    localparam int FS_ME  = 16;

    // Enable-register bits accepted from a bus write.
    function automatic logic [31:0] en_wmask(logic [3:0] impl);
        return (impl == 4'd0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    // Enable-register bits that survive a reset.
    function automatic logic [31:0] en_keep(logic [3:0] impl);
        return (impl == 4'd0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    // Implementation code placed in the top nibble.
    function automatic logic [31:0] code_word(logic [3:0] impl);
        return {impl, 28'h0};
    endfunction

endpackage

// File: rtl/ecc_csr_decode.sv
// Address decode for the register bus.
// Turns a byte address into a word index and a per-register write strobe.
// Assumes: only full-word accesses (word high) are legal; anything else,
// or an index past the last register, produces no hit and no strobe.
module ecc_csr_decode #(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 9
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                word,
    output logic [ADDR_W-3:0]   idx,
    output logic                hit,
    output logic [NUM_REGS-1:0] wr_stb
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    assign idx = addr[ADDR_W-1:2];
    assign hit = word && (idx <= LAST_IDX);

    // One write strobe per implemented register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        assign wr_stb[g] = wr && hit && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/ecc_csr_fault.sv
// Fault capture for the register bank: fault status, the two fault
// address registers and the interrupt line.
// Assumes: fstat_wr is a decoded bus write to the status register; it
// has priority over a fault presented in the same cycle, which is dropped.
module ecc_csr_fault
    import ecc_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fstat_wr,
    input  logic [31:0] wdata,
    input  logic        ce_irq_en,
    input  logic        flt_valid,
    input  logic        flt_ce,
    input  logic        flt_ue,
    input  logic [7:0]  flt_syndrome,
    input  logic [31:0] flt_far0,
    input  logic [31:0] flt_far1,
    output logic [31:0] fstat_q,
    output logic [31:0] faddr0_q,
    output logic [31:0] faddr1_q,
    output logic        irq
);
    logic accept;
    logic pending;
    logic raise;

    assign accept  = flt_valid && (flt_ce || flt_ue) && !fstat_wr;
    assign pending = fstat_q[FS_CE] || fstat_q[FS_UE];
    assign raise   = accept && (flt_ue || (flt_ce && ce_irq_en));

    // Status register: bus write, first fault load, or multiple-error merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstat_q <= '0;
        end else if (fstat_wr) begin
            fstat_q <= wdata;
        end else if (accept) begin
            if (pending) begin
                fstat_q <= fstat_q | (32'd1 << FS_ME)
                         | {28'd0, flt_ue, 2'b00, flt_ce};
            end else begin
                fstat_q <= {fstat_q[31:16], flt_syndrome, fstat_q[7:4],
                            flt_ue, fstat_q[2:1], flt_ce};
            end
        end
    end

    // Fault addresses: loaded only by the first fault of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr0_q <= FADDR0_RST;
            faddr1_q <= '0;
        end else if (accept && !pending) begin
            faddr0_q <= flt_far0;
            faddr1_q <= flt_far1;
        end
    end

    // Interrupt: set by a qualifying fault, cleared by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (fstat_wr) begin
            irq <= 1'b0;
        end else if (raise) begin
            irq <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_csr_diag.sv
// Byte-wide diagnostic window. Present only when HAS_WIN is set; the
// other variant ignores writes and reads zero.
// Assumes: one byte access per cycle, selected by addr.
module ecc_csr_diag #(
    parameter bit HAS_WIN    = 1'b1,
    parameter int DIAG_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(DIAG_BYTES)-1:0] addr,
    input  logic                          wr,
    input  logic [7:0]                    wdata,
    output logic [7:0]                    rdata
);
    if (HAS_WIN) begin : g_win
        logic [7:0] mem [DIAG_BYTES];

        // Byte storage with reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DIAG_BYTES; i++) mem[i] <= '0;
            end else if (wr) begin
                mem[addr] <= wdata;
            end
        end

        assign rdata = mem[addr];
    end else begin : g_none
        logic unused_ok;
        assign unused_ok = ^{clk, rst_n, addr, wr, wdata};
        assign rdata = '0;
    end

endmodule

// File: rtl/ecc_csr_bank.sv
// ECC controller register bank (top).
// Nine word-indexed 32-bit registers on a simple register bus, a
// fault-capture port with a level interrupt and an optional byte-wide
// diagnostic window. IMPL_CODE is static and selects the enable-register
// write mask, its reset retention and the presence of the window.
// Assumes: synchronous active-low reset; read data is combinational.
module ecc_csr_bank
    import ecc_csr_pkg::*;
#(
    parameter logic [3:0] IMPL_CODE  = 4'd1,
    parameter int         ADDR_W     = 6,
    parameter int         DIAG_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic                          reg_word,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          flt_valid,
    input  logic                          flt_ce,
    input  logic                          flt_ue,
    input  logic [7:0]                    flt_syndrome,
    input  logic [31:0]                   flt_far0,
    input  logic [31:0]                   flt_far1,
    output logic                          irq,
    input  logic [$clog2(DIAG_BYTES)-1:0] dg_addr,
    input  logic                          dg_wr,
    input  logic [7:0]                    dg_wdata,
    output logic [7:0]                    dg_rdata
);
    localparam int          IDX_W     = ADDR_W - 2;
    localparam logic [31:0] EN_WMASK  = en_wmask(IMPL_CODE);
    localparam logic [31:0] EN_KEEP   = en_keep(IMPL_CODE);
    localparam logic [31:0] CODE_WORD = code_word(IMPL_CODE);
    localparam bit          HAS_WIN   = (IMPL_CODE == 4'd0);

    logic [IDX_W-1:0]    idx;
    logic                hit;
    logic [NUM_REGS-1:0] wr_stb;

    logic [31:0] en_q, dly_q, vcfg_q, dreg_q, evc0_q, evc1_q;
    logic [31:0] fstat_q, faddr0_q, faddr1_q;
    logic        unused_ok;

    assign unused_ok = ^{wr_stb[IDX_FADDR0], wr_stb[IDX_FADDR1]};

    ecc_csr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .addr   (reg_addr),
        .wr     (reg_wr),
        .word   (reg_word),
        .idx    (idx),
        .hit    (hit),
        .wr_stb (wr_stb)
    );

    ecc_csr_fault u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .fstat_wr     (wr_stb[IDX_FSTAT]),
        .wdata        (reg_wdata),
        .ce_irq_en    (en_q[1]),
        .flt_valid    (flt_valid),
        .flt_ce       (flt_ce),
        .flt_ue       (flt_ue),
        .flt_syndrome (flt_syndrome),
        .flt_far0     (flt_far0),
        .flt_far1     (flt_far1),
        .fstat_q      (fstat_q),
        .faddr0_q     (faddr0_q),
        .faddr1_q     (faddr1_q),
        .irq          (irq)
    );

    ecc_csr_diag #(
        .HAS_WIN    (HAS_WIN),
        .DIAG_BYTES (DIAG_BYTES)
    ) u_diag (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (dg_addr),
        .wr    (dg_wr),
        .wdata (dg_wdata),
        .rdata (dg_rdata)
    );

    // Enable register: masked write, partial retention across reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= (en_q & EN_KEEP) | CODE_WORD;
        end else if (wr_stb[IDX_EN]) begin
            en_q <= (reg_wdata & EN_WMASK) | CODE_WORD;
        end
    end

    // Delay register: top bit never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= DLY_RST;
        end else if (wr_stb[IDX_DLY]) begin
            dly_q <= reg_wdata & DLY_WMASK;
        end
    end

    // Plain full-word registers: video config, diagnostic, two event counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcfg_q <= '0;
            dreg_q <= '0;
            evc0_q <= '0;
            evc1_q <= '0;
        end else begin
            if (wr_stb[IDX_VCFG]) vcfg_q <= reg_wdata;
            if (wr_stb[IDX_DREG]) dreg_q <= reg_wdata;
            if (wr_stb[IDX_EVC0]) evc0_q <= reg_wdata;
            if (wr_stb[IDX_EVC1]) evc1_q <= reg_wdata;
        end
    end

    // Read multiplexer: zero for partial accesses and unused indices.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (idx)
                IDX_W'(IDX_EN):     reg_rdata = en_q;
                IDX_W'(IDX_DLY):    reg_rdata = dly_q;
                IDX_W'(IDX_FSTAT):  reg_rdata = fstat_q;
                IDX_W'(IDX_VCFG):   reg_rdata = vcfg_q;
                IDX_W'(IDX_FADDR0): reg_rdata = faddr0_q;
                IDX_W'(IDX_FADDR1): reg_rdata = faddr1_q;
                IDX_W'(IDX_DREG):   reg_rdata = dreg_q;
                IDX_W'(IDX_EVC0):   reg_rdata = evc0_q;
                IDX_W'(IDX_EVC1):   reg_rdata = evc1_q;
                default:            reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ecc_csr_bank_chk.sv
// Property checker for ecc_csr_bank, attached by bind.
// Assumes: flt_valid is sampled on the same edge as bus writes.
module ecc_csr_bank_chk #(
    parameter logic [3:0] IMPL_CODE = 4'd1,
    parameter int         ADDR_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_word,
    input logic [31:0]       reg_rdata,
    input logic              flt_valid,
    input logic              flt_ce,
    input logic              flt_ue,
    input logic              irq,
    input logic [31:0]       fstat_q,
    input logic [31:0]       faddr0_q,
    input logic [31:0]       faddr1_q
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             st_wr;
    logic             accept;

    assign idx    = reg_addr[ADDR_W-1:2];
    assign st_wr  = reg_wr && reg_word && (idx == IDX_W'(2));
    assign accept = flt_valid && (flt_ce || flt_ue) && !st_wr;

    AST_CODE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word && idx == IDX_W'(0)) |-> (reg_rdata[31:28] == IMPL_CODE)); // R1
    AST_DELAY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word && idx == IDX_W'(1)) |-> !reg_rdata[31]); // R2
    AST_FADDR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word && (idx == IDX_W'(4) || idx == IDX_W'(5)) && !flt_valid)
        |=> ($stable(faddr0_q) && $stable(faddr1_q))); // R5
    AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_word |-> (reg_rdata == 32'd0)); // R6
    AST_HIGH_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word && idx > IDX_W'(8)) |-> (reg_rdata == 32'd0)); // R7
    AST_MULTI_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (fstat_q[0] || fstat_q[3])) |=> fstat_q[16]); // R9
    AST_UE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flt_ue) |=> irq); // R10
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !st_wr) |=> irq); // R10
    AST_STATUS_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> !irq); // R11

endmodule

bind ecc_csr_bank ecc_csr_bank_chk #(
    .IMPL_CODE (IMPL_CODE),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .reg_rdata (reg_rdata),
    .flt_valid (flt_valid),
    .flt_ce    (flt_ce),
    .flt_ue    (flt_ue),
    .irq       (irq),
    .fstat_q   (fstat_q),
    .faddr0_q  (faddr0_q),
    .faddr1_q  (faddr1_q)
);

// File: tb/ecc_csr_bank_tb.sv
// Bench for ecc_csr_bank: one instance with code 1 (u_dut) driven by
// directed and seeded random traffic against a bench model, and one with
// code 0 (u_dut0) for the code-0 masks and the diagnostic window.
module ecc_csr_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam logic [31:0] KEEP1 = 32'hFF00_0BFC;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n;
    logic [AW-1:0] a_addr, z_addr;
    logic        a_wr, a_word, z_wr, z_word;
    logic [31:0] a_wdata, z_wdata, a_rdata, z_rdata;
    logic        f_valid, f_ce, f_ue;
    logic [7:0]  f_syn;
    logic [31:0] f_far0, f_far1;
    logic        a_irq, z_irq;
    logic [1:0]  ad_addr, zd_addr;
    logic        ad_wr, zd_wr;
    logic [7:0]  ad_wdata, zd_wdata, ad_rdata, zd_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m [9];
    logic        m_irq;

    ecc_csr_bank #(.IMPL_CODE(4'd1), .ADDR_W(AW), .DIAG_BYTES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(a_addr), .reg_wr(a_wr),
        .reg_word(a_word), .reg_wdata(a_wdata), .reg_rdata(a_rdata),
        .flt_valid(f_valid), .flt_ce(f_ce), .flt_ue(f_ue),
        .flt_syndrome(f_syn), .flt_far0(f_far0), .flt_far1(f_far1),
        .irq(a_irq), .dg_addr(ad_addr), .dg_wr(ad_wr),
        .dg_wdata(ad_wdata), .dg_rdata(ad_rdata));

    ecc_csr_bank #(.IMPL_CODE(4'd0), .ADDR_W(AW), .DIAG_BYTES(4)) u_dut0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(z_addr), .reg_wr(z_wr),
        .reg_word(z_word), .reg_wdata(z_wdata), .reg_rdata(z_rdata),
        .flt_valid(1'b0), .flt_ce(1'b0), .flt_ue(1'b0),
        .flt_syndrome(8'd0), .flt_far0(32'd0), .flt_far1(32'd0),
        .irq(z_irq), .dg_addr(zd_addr), .dg_wr(zd_wr),
        .dg_wdata(zd_wdata), .dg_rdata(zd_rdata));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the code-1 instance.
    function automatic void model_reset();
        m[0] = (m[0] & KEEP1) | 32'h1000_0000;
        m[1] = 32'h20; m[2] = 0; m[3] = 0; m[4] = 32'h07C0_0000;
        m[5] = 0; m[6] = 0; m[7] = 0; m[8] = 0;
        m_irq = 1'b0;
    endfunction

    function automatic void model_wr(int idx, logic [31:0] d);
        case (idx)
            0: m[0] = (d & 32'h0000_0BFF) | 32'h1000_0000;
            1: m[1] = d & 32'h7FFF_FFFF;
            2: begin m[2] = d; m_irq = 1'b0; end
            3, 6, 7, 8: m[idx] = d;
            default: ;
        endcase
    endfunction

    function automatic void model_flt(logic ce, logic ue, logic [7:0] syn,
                                      logic [31:0] f0, logic [31:0] f1);
        if (!(ce || ue)) return;
        if (m[2][0] || m[2][3]) begin
            m[2] = m[2] | 32'h0001_0000 | {28'd0, ue, 2'b00, ce};
        end else begin
            m[2] = {m[2][31:16], syn, m[2][7:4], ue, m[2][2:1], ce};
            m[4] = f0;
            m[5] = f1;
        end
        if (ue || (ce && m[0][1])) m_irq = 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(bit z, int idx, logic [31:0] d, bit word = 1'b1);
        @(negedge clk);
        if (z) begin z_addr = AW'(idx << 2); z_wr = 1; z_word = word; z_wdata = d; end
        else begin a_addr = AW'(idx << 2); a_wr = 1; a_word = word; a_wdata = d; end
        @(negedge clk);
        z_wr = 0; z_word = 1; a_wr = 0; a_word = 1;
        if (!z && word) model_wr(idx, d);
    endtask

    task automatic rd(bit z, int idx, output logic [31:0] v, input bit word = 1'b1);
        @(negedge clk);
        if (z) begin z_addr = AW'(idx << 2); z_word = word; end
        else begin a_addr = AW'(idx << 2); a_word = word; end
        #1;
        v = z ? z_rdata : a_rdata;
        z_word = 1; a_word = 1;
    endtask

    task automatic fault(logic ce, logic ue, logic [7:0] syn,
                         logic [31:0] f0, logic [31:0] f1);
        @(negedge clk);
        f_valid = 1; f_ce = ce; f_ue = ue; f_syn = syn; f_far0 = f0; f_far1 = f1;
        @(negedge clk);
        f_valid = 0;
        model_flt(ce, ue, syn, f0, f1);
    endtask

    task automatic dg_wr_t(bit z, int a, logic [7:0] d);
        @(negedge clk);
        if (z) begin zd_addr = 2'(a); zd_wr = 1; zd_wdata = d; end
        else begin ad_addr = 2'(a); ad_wr = 1; ad_wdata = d; end
        @(negedge clk);
        zd_wr = 0; ad_wr = 0;
    endtask

    task automatic dg_rd_t(bit z, int a, output logic [7:0] v);
        @(negedge clk);
        if (z) zd_addr = 2'(a); else ad_addr = 2'(a);
        #1;
        v = z ? zd_rdata : ad_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(0, i, v);
            chk(req, v, m[i]);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        void'($urandom(32'd4242));
        rst_n = 0;
        a_addr = 0; a_wr = 0; a_word = 1; a_wdata = 0;
        z_addr = 0; z_wr = 0; z_word = 1; z_wdata = 0;
        f_valid = 0; f_ce = 0; f_ue = 0; f_syn = 0; f_far0 = 0; f_far1 = 0;
        ad_addr = 0; ad_wr = 0; ad_wdata = 0;
        zd_addr = 0; zd_wr = 0; zd_wdata = 0;
        for (int i = 0; i < 9; i++) m[i] = 0;
        do_reset();

        // R3: reset values
        rd(0, 0, v);
        chk("R3 enable non-kept bits", v & ~KEEP1, 32'd0);
        chk("R3 enable code nibble", {28'd0, v[31:28]}, 32'd1);
        m[0] = v;
        for (int i = 1; i < 9; i++) begin
            rd(0, i, v);
            chk("R3 reset value", v, m[i]);
        end
        chk("R3 irq low", {31'd0, a_irq}, 32'd0);

        // R1: enable write masks, both codes
        wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, v); chk("R1 code1 all ones", v, 32'h1000_0BFF);
        wr(0, 0, 32'h0000_0000); rd(0, 0, v); chk("R1 code1 zero", v, 32'h1000_0000);
        wr(1, 0, 32'hFFFF_FFFF); rd(1, 0, v); chk("R1 code0 all ones", v, 32'h0000_0103);

        // R2: delay top bit
        wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, v); chk("R2 delay mask", v, 32'h7FFF_FFFF);

        // R13 and R7: plain registers, event counters separate
        wr(0, 3, 32'hDEAD_BEEF); wr(0, 6, 32'h1234_5678);
        wr(0, 7, 32'hA5A5_0001); wr(0, 8, 32'h5A5A_0002);
        rd(0, 3, v); chk("R13 video config", v, 32'hDEAD_BEEF);
        rd(0, 6, v); chk("R13 diagnostic reg", v, 32'h1234_5678);
        rd(0, 7, v); chk("R7 event 0 separate", v, 32'hA5A5_0001);
        rd(0, 8, v); chk("R7 event 1 separate", v, 32'h5A5A_0002);

        // R5: fault addresses read-only
        wr(0, 4, 32'hFFFF_FFFF); wr(0, 5, 32'hFFFF_FFFF);
        rd(0, 4, v); chk("R5 fault addr 0", v, 32'h07C0_0000);
        rd(0, 5, v); chk("R5 fault addr 1", v, 32'h0);

        // R7: high indices
        for (int i = 9; i < 16; i++) begin
            wr(0, i, 32'hFFFF_FFFF);
            rd(0, i, v); chk("R7 high index reads zero", v, 32'd0);
        end
        check_all("R7 high writes harmless");

        // R6: partial accesses
        wr(0, 3, 32'h0BAD_0BAD, 1'b0);
        rd(0, 3, v); chk("R6 partial write ignored", v, 32'hDEAD_BEEF);
        rd(0, 3, v, 1'b0); chk("R6 partial read zero", v, 32'd0);

        // R8, R9, R10, R11: fault capture
        wr(0, 0, 32'h0); wr(0, 2, 32'h0);
        fault(1, 0, 8'hA5, 32'h1111_0000, 32'h2222_0000);
        rd(0, 2, v); chk("R8 status load", v, 32'h0000_A501);
        rd(0, 4, v); chk("R8 fault addr 0", v, 32'h1111_0000);
        rd(0, 5, v); chk("R8 fault addr 1", v, 32'h2222_0000);
        chk("R10 ce without enable", {31'd0, a_irq}, 32'd0);
        fault(0, 1, 8'h3C, 32'h3333_0000, 32'h4444_0000);
        rd(0, 2, v); chk("R9 multiple error", v, 32'h0001_A509);
        rd(0, 4, v); chk("R9 address kept", v, 32'h1111_0000);
        chk("R10 ue raises irq", {31'd0, a_irq}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R10 irq held", {31'd0, a_irq}, 32'd1);
        wr(0, 2, 32'h0);
        chk("R11 status write clears irq", {31'd0, a_irq}, 32'd0);
        wr(0, 0, 32'h2);
        fault(1, 0, 8'h01, 32'h5, 32'h6);
        chk("R10 ce with enable", {31'd0, a_irq}, 32'd1);

        // R11: collision, bus write wins, fault dropped
        @(negedge clk);
        a_addr = AW'(2 << 2); a_wr = 1; a_wdata = 32'h0000_0055;
        f_valid = 1; f_ce = 0; f_ue = 1; f_syn = 8'hEE;
        f_far0 = 32'h7777_7777; f_far1 = 32'h8888_8888;
        @(negedge clk);
        a_wr = 0; f_valid = 0;
        model_wr(2, 32'h0000_0055);
        #1;
        chk("R11 collision irq", {31'd0, a_irq}, 32'd0);
        rd(0, 2, v); chk("R11 collision status", v, 32'h0000_0055);
        rd(0, 4, v); chk("R11 collision fault dropped", v, m[4]);

        // R12: diagnostic window
        for (int i = 0; i < 4; i++) dg_wr_t(1, i, 8'(8'h40 + i));
        for (int i = 0; i < 4; i++) begin
            dg_rd_t(1, i, b); chk("R12 code0 window", {24'd0, b}, {24'd0, 8'(8'h40 + i)});
        end
        dg_wr_t(0, 2, 8'hFF);
        dg_rd_t(0, 2, b); chk("R12 code1 no window", {24'd0, b}, 32'd0);

        // R4: reset retention, both codes
        wr(0, 0, 32'hFFFF_FFFF);
        do_reset();
        rd(0, 0, v); chk("R4 code1 retention", v, 32'h1000_0BFC);
        rd(1, 0, v); chk("R4 code0 retention", v, 32'h0000_0100);
        check_all("R3 after second reset");

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int op;
            int idx;
            op  = int'($urandom % 10);
            idx = int'($urandom % 16);
            if (op < 4) begin
                logic [31:0] d;
                d = $urandom;
                if (idx == 2 && ($urandom % 2) == 1) d = 32'h0;
                wr(0, idx, d);
            end else if (op < 7) begin
                rd(0, idx, v);
                chk("R13 random read", v, (idx < 9) ? m[idx] : 32'd0);
            end else if (op < 9) begin
                fault(1'($urandom), 1'($urandom), 8'($urandom), $urandom, $urandom);
            end else begin
                wr(0, idx, $urandom, 1'b0);
                rd(0, idx, v, 1'b0);
                chk("R6 random partial read", v, 32'd0);
            end
            #1;
            chk("R10 random irq", {31'd0, a_irq}, {31'd0, m_irq});
        end
        check_all("R8 final state");

        summary();
        $finish;
    end

endmodule